// File: doc/BRIEF.md
# Three-Phase Load/Store Pipeline with One Branch Delay Slot

This block is a small in-order processor core for a fixed-width load/store instruction set. An instruction that works only on registers needs two phases: fetch, then execute. In the execute phase the core reads two registers, runs the ALU and writes the result to a register. Loads and stores add a third phase. The execute phase forms the memory address, and the memory phase moves the data between a register and data memory. Instruction memory and data memory are outside the core. Both are synchronous arrays: they take an address and enable in one cycle and return read data on the next clock edge.

Control transfer is delayed. When a jump executes, the instruction fetched right after it, the delay slot, always completes. The first instruction at the jump target is fetched only after the delay slot. Nothing is flushed. A compiler may put a NOOP in the slot, or move an earlier independent instruction into it. Either way the result matches the plain, undelayed order. The execute-stage result is forwarded to the next instruction. A load followed at once by a consumer of the loaded value costs one stall cycle. A halt instruction freezes the core so that a test program can end.

Instruction word, most significant field first: opcode [31:28], destination [27:24], first source [23:20], second source [19:16], immediate [15:0]. Opcodes are as follows: 0 is no operation, 1 is add, 2 is subtract, 3 is load, 4 is store, 5 is jump, and F is halt.

Top module: `dlyslot_core`

## Requirements
- R1: While reset is held, the fetch address is 0, both data-memory strobes are low and `halted` is low. The first fetch after reset is from address 0.
- R2: Opcode 1 writes rs1 + rs2 + sign-extended imm into rd. Opcode 2 writes rs1 − rs2 into rd. Arithmetic is modulo 2^XLEN.
- R3: Register 0 always reads as zero, and writes to it are discarded. This includes a value that would otherwise be forwarded.
- R4: The result of an add or subtract can be used by the very next instruction, as either source, with no stall.
- R5: A load (opcode 3) writes the data-memory word at rs1 + sign-extended imm into rd. A store (opcode 4) writes rs2 to that address. The address is the low DA_W bits of the sum. A load that directly follows a store to the same address returns the stored value.
- R6: When an instruction reads, as a source or as store data, the register loaded by the instruction directly before it, the core inserts exactly one stall cycle. Reordering the program so that an independent instruction sits between the two removes that cycle.
- R7: A jump (opcode 5) sets the fetch address to imm[PC_W-1:0]. The single instruction after the jump executes, and execution then continues at the target. A straight-line program of N instructions ending in a halt raises `halted` N+1 cycles after reset is released.
- R8: When a halt (opcode F) executes, `halted` rises one cycle later and stays high. No later instruction executes, no data-memory access occurs, and the fetch address freezes.
- R9: Any other opcode acts as a no-operation: no register write and no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_en | output | 1 | Instruction-memory read enable; low while the core holds |
| imem_addr | output | PC_W | Instruction fetch address (word index) |
| imem_rdata | input | 32 | Instruction word, returned one edge after the address |
| dmem_re | output | 1 | Data-memory read strobe for a load |
| dmem_we | output | 1 | Data-memory write strobe for a store |
| dmem_addr | output | DA_W | Data-memory word address |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data, returned one edge after the read strobe |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Two functions can meet in one cycle. A load writes its memory-phase data into the register file while the instruction that needs that register is held in execute by the stall logic. Store data can also be forwarded in the same cycle that the store's address is formed. The bench provokes this with load→add and load→store pairs and with a store→load pair at the same address. It judges the values written back to data memory, and it checks that the halt cycle is exactly one later than in a reordered version of the same program. An operand sweep with back-to-back dependent adds and subtracts covers forwarding. A jump with a live delay slot and skipped instructions after it covers sequencing.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   localparam int INSN_W = 32;

   localparam logic [3:0] OPC_NOP   = 4'h0;
   localparam logic [3:0] OPC_ADD   = 4'h1;
   localparam logic [3:0] OPC_SUB   = 4'h2;
   localparam logic [3:0] OPC_LOAD  = 4'h3;
   localparam logic [3:0] OPC_STORE = 4'h4;
   localparam logic [3:0] OPC_JUMP  = 4'h5;
   localparam logic [3:0] OPC_HALT  = 4'hF;

   typedef struct packed {
      logic        add;
      logic        sub;
      logic        load;
      logic        store;
      logic        jump;
      logic        halt;
      logic        use_a;
      logic        use_b;
      logic [3:0]  rd;
      logic [3:0]  ra;
      logic [3:0]  rb;
      logic [15:0] imm;
   } dec_t;

   function automatic dec_t decode(input logic [INSN_W-1:0] ins);
      dec_t       d;
      logic [3:0] op;
      op      = ins[31:28];
      d.add   = (op == OPC_ADD);
      d.sub   = (op == OPC_SUB);
      d.load  = (op == OPC_LOAD);
      d.store = (op == OPC_STORE);
      d.jump  = (op == OPC_JUMP);
      d.halt  = (op == OPC_HALT);
      d.use_a = d.add | d.sub | d.load | d.store;
      d.use_b = d.add | d.sub | d.store;
      d.rd    = ins[27:24];
      d.ra    = ins[23:20];
      d.rb    = ins[19:16];
      d.imm   = ins[15:0];
      return d;
   endfunction

endpackage

// File: rtl/dsc_regfile.sv
module dsc_regfile #(
   parameter int NREG = 16,
   parameter int XLEN = 32,
   localparam int RA_W = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wen,
   input  logic [RA_W-1:0] waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [RA_W-1:0] raddr_a,
   input  logic [RA_W-1:0] raddr_b,
   output logic [XLEN-1:0] rdata_a,
   output logic [XLEN-1:0] rdata_b
);

   logic [XLEN-1:0] regs [NREG];

   for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
      if (gi == 0) begin : g_zero
         assign regs[gi] = '0;
      end else begin : g_flop
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wen && waddr == RA_W'(gi))
               q <= wdata;
         end
         assign regs[gi] = q;
      end
   end

   assign rdata_a = regs[raddr_a];
   assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/dsc_exec.sv
module dsc_exec #(
   parameter int XLEN = 32
) (
   input  logic            do_add,
   input  logic            do_sub,
   input  logic            do_mem,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [15:0]     imm,
   output logic [XLEN-1:0] result
);

   localparam int EXT_W = XLEN - 16;

   logic [XLEN-1:0] simm;
   logic [XLEN-1:0] sum3;
   logic [XLEN-1:0] diff;
   logic [XLEN-1:0] addr;

   assign simm = {{EXT_W{imm[15]}}, imm};
   assign sum3 = opa + opb + simm;
   assign diff = opa - opb;
   assign addr = opa + simm;

   always_comb begin
      if (do_sub)
         result = diff;
      else if (do_mem)
         result = addr;
      else if (do_add)
         result = sum3;
      else
         result = '0;
   end

endmodule

// File: rtl/dsc_hazard.sv
module dsc_hazard #(
   parameter int NREG   = 16,
   parameter bit FWD_EN = 1'b1,
   localparam int RA_W  = $clog2(NREG)
) (
   input  logic            e_valid,
   input  logic            use_a,
   input  logic            use_b,
   input  logic [RA_W-1:0] ra,
   input  logic [RA_W-1:0] rb,
   input  logic            m_valid,
   input  logic            m_load,
   input  logic [RA_W-1:0] m_rd,
   output logic            stall,
   output logic            fwd_a,
   output logic            fwd_b
);

   logic hit_a;
   logic hit_b;

   assign hit_a = e_valid && use_a && ra != '0 && m_valid && ra == m_rd;
   assign hit_b = e_valid && use_b && rb != '0 && m_valid && rb == m_rd;

   if (FWD_EN) begin : g_fwd
      assign stall = m_load && (hit_a || hit_b);
      assign fwd_a = hit_a && !m_load;
      assign fwd_b = hit_b && !m_load;
   end else begin : g_nofwd
      assign stall = hit_a || hit_b;
      assign fwd_a = 1'b0;
      assign fwd_b = 1'b0;
   end

endmodule

// File: rtl/dsc_fetch.sv
module dsc_fetch #(
   parameter int PC_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   input  logic            redirect,
   input  logic [PC_W-1:0] target,
   output logic [PC_W-1:0] pc
);

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_nxt;

   always_comb begin
      if (hold)
         pc_nxt = pc_q;
      else if (redirect)
         pc_nxt = target;
      else
         pc_nxt = pc_q + PC_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_q <= '0;
      else
         pc_q <= pc_nxt;
   end

   assign pc = pc_q;

   AST_HOLD_FREEZES_PC: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(pc)); // R6

endmodule

// File: rtl/dlyslot_core.sv
module dlyslot_core #(
   parameter int XLEN   = 32,
   parameter int NREG   = 16,
   parameter int PC_W   = 8,
   parameter int DA_W   = 8,
   parameter bit FWD_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   output logic                      imem_en,
   output logic [PC_W-1:0]           imem_addr,
   input  logic [dsc_pkg::INSN_W-1:0] imem_rdata,
   output logic                      dmem_re,
   output logic                      dmem_we,
   output logic [DA_W-1:0]           dmem_addr,
   output logic [XLEN-1:0]           dmem_wdata,
   input  logic [XLEN-1:0]           dmem_rdata,
   output logic                      halted
);
   import dsc_pkg::*;

   localparam int RA_W = $clog2(NREG);

   if (XLEN <= 16) begin : g_bad_xlen
      $error("XLEN must exceed the 16-bit immediate");
   end
   if (NREG < 2 || NREG > 16 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two from 2 to 16");
   end
   if (PC_W < 2 || PC_W > 16) begin : g_bad_pcw
      $error("PC_W must lie in 2..16");
   end
   if (DA_W < 1 || DA_W > XLEN) begin : g_bad_daw
      $error("DA_W must lie in 1..XLEN");
   end

   // execute-stage state
   logic            e_valid_q;
   logic            halted_q;
   dec_t            e_dec;
   logic [RA_W-1:0] ra_idx;
   logic [RA_W-1:0] rb_idx;
   logic [RA_W-1:0] rd_idx;
   logic [XLEN-1:0] rf_a;
   logic [XLEN-1:0] rf_b;
   logic [XLEN-1:0] op_a;
   logic [XLEN-1:0] op_b;
   logic [XLEN-1:0] ex_res;
   logic            stall;
   logic            fwd_a;
   logic            fwd_b;
   logic            e_fire;
   logic            e_jump;
   logic            e_halt;
   logic            e_other;
   logic            hold;

   // memory-stage state
   logic            m_valid_q;
   logic            m_load_q;
   logic [RA_W-1:0] m_rd_q;
   logic [XLEN-1:0] m_res_q;
   logic            wb_en;
   logic [XLEN-1:0] wb_data;

   assign e_dec  = decode(imem_rdata);
   assign ra_idx = e_dec.ra[RA_W-1:0];
   assign rb_idx = e_dec.rb[RA_W-1:0];
   assign rd_idx = e_dec.rd[RA_W-1:0];

   dsc_hazard #(.NREG(NREG), .FWD_EN(FWD_EN)) u_hazard (
      .e_valid (e_valid_q),
      .use_a   (e_dec.use_a),
      .use_b   (e_dec.use_b),
      .ra      (ra_idx),
      .rb      (rb_idx),
      .m_valid (m_valid_q),
      .m_load  (m_load_q),
      .m_rd    (m_rd_q),
      .stall   (stall),
      .fwd_a   (fwd_a),
      .fwd_b   (fwd_b)
   );

   assign e_fire  = e_valid_q && !stall;
   assign e_jump  = e_fire && e_dec.jump;
   assign e_halt  = e_fire && e_dec.halt;
   assign e_other = e_fire && !(e_dec.use_a || e_dec.jump || e_dec.halt);
   assign hold    = stall || halted_q || e_halt;

   dsc_fetch #(.PC_W(PC_W)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .redirect (e_jump),
      .target   (e_dec.imm[PC_W-1:0]),
      .pc       (imem_addr)
   );

   assign imem_en = !hold;

   dsc_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen     (wb_en),
      .waddr   (m_rd_q),
      .wdata   (wb_data),
      .raddr_a (ra_idx),
      .raddr_b (rb_idx),
      .rdata_a (rf_a),
      .rdata_b (rf_b)
   );

   assign op_a = fwd_a ? m_res_q : rf_a;
   assign op_b = fwd_b ? m_res_q : rf_b;

   dsc_exec #(.XLEN(XLEN)) u_exec (
      .do_add (e_dec.add),
      .do_sub (e_dec.sub),
      .do_mem (e_dec.load || e_dec.store),
      .opa    (op_a),
      .opb    (op_b),
      .imm    (e_dec.imm),
      .result (ex_res)
   );

   assign dmem_addr  = ex_res[DA_W-1:0];
   assign dmem_wdata = op_b;
   assign dmem_we    = e_fire && e_dec.store;
   assign dmem_re    = e_fire && e_dec.load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_valid_q <= 1'b0;
         halted_q  <= 1'b0;
      end else begin
         if (!stall)
            e_valid_q <= !(halted_q || e_halt);
         if (e_halt)
            halted_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid_q <= 1'b0;
         m_load_q  <= 1'b0;
         m_rd_q    <= '0;
         m_res_q   <= '0;
      end else begin
         m_valid_q <= e_fire && (e_dec.add || e_dec.sub || e_dec.load);
         m_load_q  <= e_fire && e_dec.load;
         m_rd_q    <= rd_idx;
         m_res_q   <= ex_res;
      end
   end

   assign wb_en   = m_valid_q && m_rd_q != '0;
   assign wb_data = m_load_q ? dmem_rdata : m_res_q;
   assign halted  = halted_q;

   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      e_jump |=> imem_addr == $past(e_dec.imm[PC_W-1:0])); // R7
   AST_DELAY_SLOT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      e_jump |=> e_valid_q); // R7
   AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (e_fire && !e_dec.jump && !e_dec.halt) |=> imem_addr == $past(imem_addr) + PC_W'(1)); // R7
   AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !m_valid_q); // R6
   AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall); // R6
   AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid_q && e_dec.use_a && ra_idx == '0) |-> op_a == '0); // R3
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |=> halted_q); // R8
   AST_HALT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |-> !dmem_we && !dmem_re); // R8
   AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      e_other |=> !m_valid_q); // R9
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dmem_we, dmem_re})); // R5

endmodule

// File: tb/dlyslot_core_tb.sv
module dlyslot_core_tb;

   localparam int CLK_PERIOD = 10;
   localparam int PC_W = 8;
   localparam int DA_W = 8;
   localparam int XLEN = 32;
   localparam int RUN_LIMIT = 500;

   logic             clk = 1'b0;
   logic             rst_n = 1'b1;
   logic             imem_en;
   logic [PC_W-1:0]  imem_addr;
   logic [31:0]      imem_rdata;
   logic             dmem_re;
   logic             dmem_we;
   logic [DA_W-1:0]  dmem_addr;
   logic [XLEN-1:0]  dmem_wdata;
   logic [XLEN-1:0]  dmem_rdata;
   logic             halted;

   logic [31:0]      imem [256];
   logic [XLEN-1:0]  dmem [256];

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dlyslot_core u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_en    (imem_en),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_re    (dmem_re),
      .dmem_we    (dmem_we),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata),
      .halted     (halted)
   );

   always @(posedge clk) begin
      if (imem_en) imem_rdata <= imem[imem_addr];
      if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
      if (dmem_re) dmem_rdata <= dmem[dmem_addr];
   end

   function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                       input logic [3:0] ra, input logic [3:0] rb,
                                       input logic [15:0] imm);
      return {op, rd, ra, rb, imm};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) begin
         imem[i] = enc(4'hF, 0, 0, 0, 0);
         dmem[i] = '0;
      end
   endtask

   task automatic run_prog(output int cyc);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
      while (!halted && cyc < RUN_LIMIT) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      if (cyc >= RUN_LIMIT) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog run did not halt actual=%0d expected<%0d", cyc, RUN_LIMIT);
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int cyc;
      int cyc_a;
      int cyc_b;
      int vals [6] = '{-3, 0, 1, 32767, -32768, 5};

      // R1: reset state at the ports
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 fetch address in reset", 32'(imem_addr), 32'd0);
      check("R1 write strobe in reset", 32'(dmem_we), 32'd0);
      check("R1 read strobe in reset", 32'(dmem_re), 32'd0);
      check("R1 halted in reset", 32'(halted), 32'd0);

      // R2 / R4: operand sweep with back-to-back dependencies
      foreach (vals[i]) begin
         foreach (vals[j]) begin
            clear_mem();
            imem[0] = enc(4'h1, 1, 0, 0, 16'(vals[i]));
            imem[1] = enc(4'h1, 2, 0, 0, 16'(vals[j]));
            imem[2] = enc(4'h1, 3, 1, 2, 16'd0);   // r2 forwarded
            imem[3] = enc(4'h2, 4, 1, 2, 16'd0);
            imem[4] = enc(4'h4, 0, 0, 3, 16'd10);
            imem[5] = enc(4'h4, 0, 0, 4, 16'd11);
            imem[6] = enc(4'hF, 0, 0, 0, 16'd0);
            run_prog(cyc);
            check("R4 add of forwarded operand", dmem[10], 32'(vals[i] + vals[j]));
            check("R2 subtract", dmem[11], 32'(vals[i] - vals[j]));
         end
      end

      // R3: register zero
      clear_mem();
      imem[0] = enc(4'h1, 0, 0, 0, 16'd7);
      imem[1] = enc(4'h1, 5, 0, 0, 16'd0);
      imem[2] = enc(4'h4, 0, 0, 5, 16'd12);
      imem[3] = enc(4'h4, 0, 0, 0, 16'd13);
      imem[4] = enc(4'hF, 0, 0, 0, 16'd0);
      dmem[12] = 32'hFFFF_FFFF;
      dmem[13] = 32'hFFFF_FFFF;
      run_prog(cyc);
      check("R3 r0 not forwarded", dmem[12], 32'd0);
      check("R3 r0 reads zero", dmem[13], 32'd0);

      // R5 / R6: load-use stall versus reordered program
      clear_mem();
      imem[0] = enc(4'h1, 1, 0, 0, 16'd20);
      imem[1] = enc(4'h1, 2, 0, 0, 16'h1234);
      imem[2] = enc(4'h4, 0, 1, 2, 16'd1);
      imem[3] = enc(4'h3, 3, 1, 0, 16'd1);
      imem[4] = enc(4'h1, 4, 3, 3, 16'd0);
      imem[5] = enc(4'h1, 5, 1, 1, 16'd0);
      imem[6] = enc(4'h4, 0, 0, 4, 16'd30);
      imem[7] = enc(4'h4, 0, 0, 5, 16'd31);
      imem[8] = enc(4'hF, 0, 0, 0, 16'd0);
      run_prog(cyc_a);
      check("R5 store then load same address", dmem[30], 32'h2468);
      check("R5 store data forwarded", dmem[21], 32'h1234);
      check("R2 independent add", dmem[31], 32'd40);
      check("R6 stalled program cycles", 32'(cyc_a), 32'd11);

      clear_mem();
      imem[0] = enc(4'h1, 1, 0, 0, 16'd20);
      imem[1] = enc(4'h1, 2, 0, 0, 16'h1234);
      imem[2] = enc(4'h4, 0, 1, 2, 16'd1);
      imem[3] = enc(4'h3, 3, 1, 0, 16'd1);
      imem[4] = enc(4'h1, 5, 1, 1, 16'd0);
      imem[5] = enc(4'h1, 4, 3, 3, 16'd0);
      imem[6] = enc(4'h4, 0, 0, 4, 16'd30);
      imem[7] = enc(4'h4, 0, 0, 5, 16'd31);
      imem[8] = enc(4'hF, 0, 0, 0, 16'd0);
      run_prog(cyc_b);
      check("R5 reordered load value", dmem[30], 32'h2468);
      check("R6 reordered program cycles", 32'(cyc_b), 32'd10);
      check("R6 stall costs one cycle", 32'(cyc_a - cyc_b), 32'd1);

      // R6: load result used as store data; negative offset
      clear_mem();
      dmem[21] = 32'hCAFE_0001;
      imem[0] = enc(4'h1, 1, 0, 0, 16'd22);
      imem[1] = enc(4'h3, 6, 1, 0, 16'hFFFF);
      imem[2] = enc(4'h4, 0, 0, 6, 16'd32);
      imem[3] = enc(4'hF, 0, 0, 0, 16'd0);
      run_prog(cyc);
      check("R6 load into store data", dmem[32], 32'hCAFE_0001);
      check("R6 store-data stall cycles", 32'(cyc), 32'd6);

      // R7: delay slot executes, skipped instructions do not
      clear_mem();
      imem[0] = enc(4'h1, 1, 0, 0, 16'd1);
      imem[1] = enc(4'h5, 0, 0, 0, 16'd5);
      imem[2] = enc(4'h1, 1, 1, 0, 16'd2);
      imem[3] = enc(4'h1, 1, 1, 0, 16'd100);
      imem[4] = enc(4'h1, 1, 1, 0, 16'd1000);
      imem[5] = enc(4'h4, 0, 0, 1, 16'd40);
      imem[6] = enc(4'hF, 0, 0, 0, 16'd0);
      run_prog(cyc);
      check("R7 delay slot result", dmem[40], 32'd3);
      check("R7 jump program cycles", 32'(cyc), 32'd6);

      // R8: halt freezes the core
      clear_mem();
      dmem[50] = 32'hDEAD;
      imem[0] = enc(4'h1, 1, 0, 0, 16'd9);
      imem[1] = enc(4'hF, 0, 0, 0, 16'd0);
      imem[2] = enc(4'h4, 0, 0, 1, 16'd50);
      imem[3] = enc(4'h4, 0, 0, 1, 16'd51);
      run_prog(cyc);
      check("R8 halt cycles", 32'(cyc), 32'd3);
      check("R8 halted stays high", 32'(halted), 32'd1);
      check("R8 fetch address frozen", 32'(imem_addr), 32'd2);
      check("R8 no store after halt", dmem[50], 32'hDEAD);
      check("R8 no second store after halt", dmem[51], 32'd0);
      check("R8 no write strobe while halted", 32'(dmem_we), 32'd0);

      // R9: undefined opcodes are no-operations
      clear_mem();
      dmem[7] = 32'h55;
      imem[0] = enc(4'h1, 1, 0, 0, 16'd5);
      imem[1] = enc(4'h7, 1, 1, 1, 16'd99);
      imem[2] = enc(4'h6, 1, 0, 1, 16'd7);
      imem[3] = enc(4'h4, 0, 0, 1, 16'd60);
      imem[4] = enc(4'hF, 0, 0, 0, 16'd0);
      run_prog(cyc);
      check("R9 register untouched", dmem[60], 32'd5);
      check("R9 memory untouched", dmem[7], 32'h55);
      check("R9 program cycles", 32'(cyc), 32'd6);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog global timeout actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule